// File: doc/BRIEF.md
# Five-Pin GPIO Port with Timer Pin Takeover

This block is a small general-purpose I/O port of five pins, each with a software-controlled output latch and direction bit. The port sits next to a timer. Two of its pins can be taken over by the timer's capture/compare channels, and a third can become the timer's external clock input. For every pin the block decides whether the pad's output buffer is on and what value it drives. It also decides what a read of the data register returns. It further produces pull-up enables for the lower four pins and passes out four keyboard-interrupt pin enables. Edge detection for those interrupts is done elsewhere.

Software reaches three registers over a synchronous bus with an address, a write enable and registered read data. Timer takeover does not change the readback rule: the direction bit alone chooses between the latch and the synchronized pin level. The timer only controls pad drive.

Top module: `gpio_ovr_port`

## Requirements
- R1: While reset is low, and after it, every register is zero, so all pin_oe bits, pin_pullup bits, kbi_pin_en bits and tclk_out are 0.
- R2: A pin not owned by the timer drives pin_oe equal to its direction bit and pin_out equal to its latch bit (direction 1 = output).
- R3: Pin 1 is owned by timer channel 0 while tmr_ch_mode[1:0] is nonzero, and pin 2 is owned by channel 1 while tmr_ch_mode[3:2] is nonzero. An owned pin takes pin_oe from tmr_ch_oe[k] and pin_out from tmr_ch_out[k], and its direction bit has no effect on either.
- R4: Reading address 0 returns, in bits 4:0, the latch bit where the direction bit is 1 and the synchronized pin level where it is 0, whether or not the timer owns the pin. Bits 7:5 read 0.
- R5: Pin inputs pass through two flops. A level change applied just after one clock edge is first seen by a read captured at the third edge after it.
- R6: When tmr_clk_sel equals 3'b111, pin 0's output buffer is off regardless of its direction bit, and tclk_out follows the synchronized pin 0 level. Otherwise tclk_out is 0 and pin 0 behaves as GPIO.
- R7: pin_pullup[i] for i = 0..3 equals pull-up enable bit i AND NOT direction bit i.
- R8: kbi_pin_en equals bits 7:4 of address 2. It changes only on a write to address 2.
- R9: Register map: address 0 is the data latch (bits 4:0), address 1 is direction (bits 4:0), address 2 holds the pull-up enables in bits 3:0 and the interrupt pin enables in bits 7:4. Address 3 reads 0 and ignores writes. bus_rdata is registered at the edge where bus_addr is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 2 | Register address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| tmr_ch_mode | input | 4 | Edge/level select of channels 1 and 0, two bits each |
| tmr_clk_sel | input | 3 | Timer prescaler select |
| tmr_ch_oe | input | 2 | Per-channel compare drive enable |
| tmr_ch_out | input | 2 | Per-channel compare drive value |
| pin_in | input | 5 | Pad input levels (asynchronous) |
| pin_out | output | 5 | Pad output values |
| pin_oe | output | 5 | Pad output buffer enables |
| pin_pullup | output | 4 | Pull-up enables, pins 3..0 |
| kbi_pin_en | output | 4 | Keyboard interrupt pin enables, pins 3..0 |
| tclk_out | output | 1 | Synchronized external timer clock |

## Verification
The direction register is loaded with a mixed pattern, so some pins are outputs and some inputs, with a latch pattern that differs from the pad pattern. A readback shows whether each bit came from the latch or from the pad. The timer modes are then stepped through 01, 10 and 11 on the two channels, with timer drive values that disagree with the direction and latch bits. This separates timer control of the pad from direction control, while a read taken at the same time shows that readback still follows direction. A pad change is read at three consecutive edges to pin down the two-flop delay. Prescaler codes 3'b110 and 3'b111 are applied with pin 0 set as an output, to separate the forced-input case from ordinary GPIO.

// File: rtl/gpio_ovr_pkg.sv
`timescale 1ns/1ps
// Shared constants of the GPIO port: register addresses, bus width and
// the timer clock code. Assumes a two-bit register address space.
package gpio_ovr_pkg;
    localparam int ADDR_W = 2;
    localparam logic [ADDR_W-1:0] ADDR_DATA = 2'd0;
    localparam logic [ADDR_W-1:0] ADDR_DIR  = 2'd1;
    localparam logic [ADDR_W-1:0] ADDR_CFG  = 2'd2;
    localparam logic [2:0] TCLK_CODE = 3'b111;
    localparam int CH_BASE  = 1;   // timer channel k sits on pin CH_BASE+k
    localparam int TCLK_PIN = 0;
endpackage

// File: rtl/gpio_ovr_regs.sv
`timescale 1ns/1ps
// Register file: data latch, direction, pull-up and interrupt enables.
// Assumes 2*NPU equals the bus width DW. All fields reset to zero.
module gpio_ovr_regs
    import gpio_ovr_pkg::*;
#(
    parameter int NPINS = 5,
    parameter int NPU   = 4,
    parameter int DW    = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DW-1:0]     wdata,
    output logic [NPINS-1:0]  data_q,
    output logic [NPINS-1:0]  dir_q,
    output logic [NPU-1:0]    pue_q,
    output logic [NPU-1:0]    kbe_q
);
    // Register update on write strobe; unmapped addresses are ignored.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
            dir_q  <= '0;
            pue_q  <= '0;
            kbe_q  <= '0;
        end else if (we) begin
            case (addr)
                ADDR_DATA: data_q <= wdata[NPINS-1:0];
                ADDR_DIR:  dir_q  <= wdata[NPINS-1:0];
                ADDR_CFG: begin
                    pue_q <= wdata[NPU-1:0];
                    kbe_q <= wdata[2*NPU-1:NPU];
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/gpio_ovr_sync.sv
`timescale 1ns/1ps
// Two-flop synchronizer for W independent asynchronous pad levels.
// Assumes each bit may be sampled independently (no bus coherency).
module gpio_ovr_sync #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    // Two-stage capture of the pad levels.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1 <= '0;
            q      <= '0;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/gpio_ovr_pinmux.sv
`timescale 1ns/1ps
// Per-pin pad control: a forced input wins, then timer ownership, then
// the direction bit. Assumes timer signals are already mapped to pins.
module gpio_ovr_pinmux #(
    parameter int NPINS = 5
) (
    input  logic [NPINS-1:0] dir,
    input  logic [NPINS-1:0] latch,
    input  logic [NPINS-1:0] own,
    input  logic [NPINS-1:0] tm_oe,
    input  logic [NPINS-1:0] tm_val,
    input  logic [NPINS-1:0] force_in,
    output logic [NPINS-1:0] pin_oe,
    output logic [NPINS-1:0] pin_out
);
    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        // Buffer enable and drive value of one pin.
        assign pin_oe[i]  = force_in[i] ? 1'b0 : (own[i] ? tm_oe[i] : dir[i]);
        assign pin_out[i] = own[i] ? tm_val[i] : latch[i];
    end
endmodule

// File: rtl/gpio_ovr_port.sv
`timescale 1ns/1ps
// Five-pin GPIO port with timer pin takeover. Timer channels own their
// pins while their mode field is nonzero; pin 0 is a forced input while
// the external timer clock is selected. Readback always follows the
// direction bit. Assumes pin_in is asynchronous to clk.
module gpio_ovr_port
    import gpio_ovr_pkg::*;
#(
    parameter int NPINS = 5,
    parameter int NPU   = 4,
    parameter int NCH   = 2,
    parameter int DW    = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DW-1:0]     bus_wdata,
    output logic [DW-1:0]     bus_rdata,
    input  logic [2*NCH-1:0]  tmr_ch_mode,
    input  logic [2:0]        tmr_clk_sel,
    input  logic [NCH-1:0]    tmr_ch_oe,
    input  logic [NCH-1:0]    tmr_ch_out,
    input  logic [NPINS-1:0]  pin_in,
    output logic [NPINS-1:0]  pin_out,
    output logic [NPINS-1:0]  pin_oe,
    output logic [NPU-1:0]    pin_pullup,
    output logic [NPU-1:0]    kbi_pin_en,
    output logic              tclk_out
);
    logic [NPINS-1:0] data_q, dir_q, pin_sync;
    logic [NPU-1:0]   pue_q, kbe_q;
    logic [NPINS-1:0] own, tm_oe, tm_val, force_in;
    logic             tclk_sel;
    logic [DW-1:0]    rd_next;

    gpio_ovr_regs #(.NPINS(NPINS), .NPU(NPU), .DW(DW)) u_regs (
        .clk(clk), .rst_n(rst_n), .we(bus_we), .addr(bus_addr),
        .wdata(bus_wdata), .data_q(data_q), .dir_q(dir_q),
        .pue_q(pue_q), .kbe_q(kbe_q)
    );

    gpio_ovr_sync #(.W(NPINS)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(pin_in), .q(pin_sync)
    );

    // Map timer channels onto their pins and mark ownership.
    always_comb begin
        own    = '0;
        tm_oe  = '0;
        tm_val = '0;
        for (int k = 0; k < NCH; k++) begin
            own[CH_BASE+k]    = |tmr_ch_mode[2*k +: 2];
            tm_oe[CH_BASE+k]  = tmr_ch_oe[k];
            tm_val[CH_BASE+k] = tmr_ch_out[k];
        end
    end

    assign tclk_sel = (tmr_clk_sel == TCLK_CODE);

    // Force the external clock pin to input while it feeds the timer.
    always_comb begin
        force_in           = '0;
        force_in[TCLK_PIN] = tclk_sel;
    end

    gpio_ovr_pinmux #(.NPINS(NPINS)) u_mux (
        .dir(dir_q), .latch(data_q), .own(own), .tm_oe(tm_oe),
        .tm_val(tm_val), .force_in(force_in),
        .pin_oe(pin_oe), .pin_out(pin_out)
    );

    // Select read data; direction picks latch or pad per bit.
    always_comb begin
        rd_next = '0;
        case (bus_addr)
            ADDR_DATA: rd_next[NPINS-1:0] = (dir_q & data_q) | (~dir_q & pin_sync);
            ADDR_DIR:  rd_next[NPINS-1:0] = dir_q;
            ADDR_CFG:  rd_next[2*NPU-1:0] = {kbe_q, pue_q};
            default:   ;
        endcase
    end

    // Register the read data.
    always_ff @(posedge clk) begin
        if (!rst_n) bus_rdata <= '0;
        else        bus_rdata <= rd_next;
    end

    assign pin_pullup = pue_q & ~dir_q[NPU-1:0];
    assign kbi_pin_en = kbe_q;
    assign tclk_out   = tclk_sel & pin_sync[TCLK_PIN];
endmodule

// File: rtl/gpio_ovr_port_chk.sv
`timescale 1ns/1ps
// Assertion checker for gpio_ovr_port, attached by bind below.
// Assumes the default channel placement (channel k on pin 1+k).
module gpio_ovr_port_chk
    import gpio_ovr_pkg::*;
#(
    parameter int NPINS = 5,
    parameter int NPU   = 4,
    parameter int NCH   = 2,
    parameter int DW    = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_we,
    input logic [DW-1:0]     bus_rdata,
    input logic [2*NCH-1:0]  tmr_ch_mode,
    input logic [2:0]        tmr_clk_sel,
    input logic [NCH-1:0]    tmr_ch_oe,
    input logic [NCH-1:0]    tmr_ch_out,
    input logic [NPINS-1:0]  pin_out,
    input logic [NPINS-1:0]  pin_oe,
    input logic [NPU-1:0]    pin_pullup,
    input logic [NPU-1:0]    kbi_pin_en,
    input logic [NPINS-1:0]  dir_q,
    input logic [NPINS-1:0]  data_q
);
    p_gpio_drive_r2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |-> (pin_oe[3] == dir_q[3]) && (pin_out[3] == data_q[3]));

    p_chan0_drive_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (|tmr_ch_mode[1:0]) |-> (pin_oe[1] == tmr_ch_oe[0]) && (pin_out[1] == tmr_ch_out[0]));

    p_chan1_drive_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (|tmr_ch_mode[3:2]) |-> (pin_oe[2] == tmr_ch_oe[1]) && (pin_out[2] == tmr_ch_out[1]));

    p_readback_latch_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == ADDR_DATA) |=>
            ((bus_rdata[NPINS-1:0] & $past(dir_q)) == ($past(data_q) & $past(dir_q))));

    p_readback_upper_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == ADDR_DATA) |=> (bus_rdata[DW-1:NPINS] == '0));

    p_tclk_input_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (tmr_clk_sel == TCLK_CODE) |-> !pin_oe[TCLK_PIN]);

    p_pullup_input_r7: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |-> ((pin_pullup & dir_q[NPU-1:0]) == '0));

    p_kbi_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_we && bus_addr == ADDR_CFG) |=> $stable(kbi_pin_en));
endmodule

bind gpio_ovr_port gpio_ovr_port_chk #(
    .NPINS(NPINS), .NPU(NPU), .NCH(NCH), .DW(DW)
) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_rdata(bus_rdata), .tmr_ch_mode(tmr_ch_mode), .tmr_clk_sel(tmr_clk_sel),
    .tmr_ch_oe(tmr_ch_oe), .tmr_ch_out(tmr_ch_out), .pin_out(pin_out),
    .pin_oe(pin_oe), .pin_pullup(pin_pullup), .kbi_pin_en(kbi_pin_en),
    .dir_q(dir_q), .data_q(data_q)
);

// File: tb/gpio_ovr_port_tb.sv
`timescale 1ns/1ps
// Scoreboard bench: read tasks queue expected data, a monitor compares
// bus_rdata one edge later; pad outputs are checked directly.
module gpio_ovr_port_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] bus_addr = '0;
    logic       bus_we = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [3:0] tmr_ch_mode = '0;
    logic [2:0] tmr_clk_sel = '0;
    logic [1:0] tmr_ch_oe = '0;
    logic [1:0] tmr_ch_out = '0;
    logic [4:0] pin_in = '0;
    logic [4:0] pin_out, pin_oe;
    logic [3:0] pin_pullup, kbi_pin_en;
    logic       tclk_out;

    int checks = 0;
    int errors = 0;
    logic rd_req = 1'b0;
    logic rd_vld = 1'b0;
    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #10 clk = ~clk;

    gpio_ovr_port u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tmr_ch_mode(tmr_ch_mode),
        .tmr_clk_sel(tmr_clk_sel), .tmr_ch_oe(tmr_ch_oe), .tmr_ch_out(tmr_ch_out),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
        .pin_pullup(pin_pullup), .kbi_pin_en(kbi_pin_en), .tclk_out(tclk_out)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(logic [1:0] a, logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    // Called at a negedge: present the address, queue the expectation.
    task automatic rd_now(logic [1:0] a, logic [7:0] exp, string req);
        bus_addr = a; rd_req = 1'b1;
        exp_q.push_back(exp); tag_q.push_back(req);
        @(negedge clk);
        rd_req = 1'b0;
    endtask

    task automatic rd(logic [1:0] a, logic [7:0] exp, string req);
        @(negedge clk);
        rd_now(a, exp, req);
    endtask

    always @(posedge clk) rd_vld <= rd_req;

    // Monitor: pop one expectation per captured read.
    always @(negedge clk) begin
        if (rd_vld && exp_q.size() > 0) begin
            logic [7:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            chk(t, {24'd0, bus_rdata}, {24'd0, e});
        end
    end

    initial begin
        #(200000 * 20);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1 pin_oe", {27'd0, pin_oe}, 0);
        chk("R1 pullup", {28'd0, pin_pullup}, 0);
        chk("R1 kbi", {28'd0, kbi_pin_en}, 0);
        chk("R1 tclk", {31'd0, tclk_out}, 0);
        rst_n = 1'b1;
        rd(2'd0, 8'h00, "R1 data read");
        rd(2'd1, 8'h00, "R1 dir read");
        rd(2'd2, 8'h00, "R1 cfg read");

        // R2 / R9: plain GPIO drive
        wr(2'd1, 8'b0001_1010);
        wr(2'd0, 8'b1111_0011);
        chk("R2 pin_oe", {27'd0, pin_oe}, 32'b11010);
        chk("R2 pin_out", {27'd0, pin_out}, 32'b10011);
        rd(2'd1, 8'b0001_1010, "R9 dir readback");

        // R4: mixed latch/pad readback
        pin_in = 5'b01100;
        repeat (4) @(negedge clk);
        rd(2'd0, 8'b0001_0110, "R4 mixed readback");

        // R5: two-flop delay, reads captured at edges 1, 2, 3 after change
        @(negedge clk);
        pin_in = 5'b00001;
        rd_now(2'd0, 8'b0001_0110, "R5 edge1 old");
        rd_now(2'd0, 8'b0001_0110, "R5 edge2 old");
        rd_now(2'd0, 8'b0001_0011, "R5 edge3 new");

        // R9: address 3 reads zero and ignores writes
        wr(2'd3, 8'hFF);
        rd(2'd3, 8'h00, "R9 addr3 read");
        rd(2'd0, 8'b0001_0011, "R9 data after addr3 write");
        rd(2'd1, 8'b0001_1010, "R9 dir after addr3 write");

        // R7 / R8: pull-ups and interrupt enables
        wr(2'd2, 8'b1010_1111);
        chk("R7 pullup", {28'd0, pin_pullup}, 32'b0101);
        chk("R8 kbi", {28'd0, kbi_pin_en}, 32'b1010);
        rd(2'd2, 8'hAF, "R9 cfg readback");
        wr(2'd0, 8'h00);
        chk("R8 kbi unchanged", {28'd0, kbi_pin_en}, 32'b1010);
        wr(2'd0, 8'b0001_0011);

        // R3: channel 1 owns pin 2, direction bit 0 overridden
        @(negedge clk);
        tmr_ch_mode = 4'b0100; tmr_ch_oe = 2'b10; tmr_ch_out = 2'b10;
        #1;
        chk("R3 ch1 oe", {27'd0, pin_oe}, 32'b11110);
        chk("R3 ch1 out", {27'd0, pin_out}, 32'b10111);
        // R3: both channels, pin 1 direction 1 overridden to off
        tmr_ch_mode = 4'b1110; tmr_ch_oe = 2'b00; tmr_ch_out = 2'b00;
        #1;
        chk("R3 both oe", {27'd0, pin_oe}, 32'b11000);
        chk("R3 both out", {27'd0, pin_out}, 32'b10001);
        chk("R7 pullup under takeover", {28'd0, pin_pullup}, 32'b0101);
        // R4: readback still by direction while owned
        rd(2'd0, 8'b0001_0011, "R4 readback while owned");
        @(negedge clk);
        tmr_ch_mode = 4'b0000;
        #1;
        chk("R2 released oe", {27'd0, pin_oe}, 32'b11010);

        // R6: external timer clock
        wr(2'd1, 8'b0001_1011);
        tmr_clk_sel = 3'b110;
        #1;
        chk("R6 not selected oe", {27'd0, pin_oe}, 32'b11011);
        chk("R6 not selected tclk", {31'd0, tclk_out}, 0);
        chk("R7 pullup new dir", {28'd0, pin_pullup}, 32'b0100);
        tmr_clk_sel = 3'b111;
        #1;
        chk("R6 selected oe", {27'd0, pin_oe}, 32'b11010);
        chk("R6 tclk high", {31'd0, tclk_out}, 1);
        @(negedge clk);
        pin_in = 5'b00000;
        repeat (3) @(negedge clk);
        chk("R6 tclk low", {31'd0, tclk_out}, 0);

        // R1: reset again clears everything
        rst_n = 1'b0;
        tmr_clk_sel = 3'b000;
        repeat (2) @(negedge clk);
        chk("R1 rereset oe", {27'd0, pin_oe}, 0);
        chk("R1 rereset kbi", {28'd0, kbi_pin_en}, 0);
        rst_n = 1'b1;
        rd(2'd2, 8'h00, "R1 rereset cfg");

        repeat (3) @(negedge clk);
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL scoreboard: actual %0d pending expected 0", exp_q.size());
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule